// File: doc/BRIEF.md
# Alarm Priority Arbiter with Temporal Horn

This block sits between the detection logic of a smoke alarm and its sounders. Every clock it looks at six condition flags: local smoke, an alarm arriving over the interconnect line from another unit, a passed or failed push-test, low battery, and a degraded sensing chamber. It picks the single condition that wins a fixed priority and reports it as a 3-bit alarm-type code. It also raises an inhibit that masks the trouble warnings whenever an alarm or a test is active, and an LED select that marks a remote alarm apart from a local one.

For the conditions that sound the horn (local alarm, remote alarm, passed test), the block drives the horn enable with the three-pulse temporal cadence. The cadence has three on units, each followed by an off unit, with the last off stretched to three units. One unit is `PHASE_TICKS` pulses of the `tick` strobe, and the block's owner sets `tick` so that one unit lasts half a second. The indication lasts as long as the condition does. The cadence starts again from its first on unit whenever a horn-sounding condition takes over.

All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.

Top module: `alarm_arbiter`

## Requirements
- R1: When `smoke_local` is high, `alarm_code` is 1 (local) whatever the other inputs are.
- R2: When `remote_in` is high and `smoke_local` is low, `alarm_code` is 2 (remote), even while a test result is present.
- R3: With neither alarm present, a passed test (`test_pass`) gives code 3 and a failed test (`test_fail`) alone gives code 4; if both are high, the pass wins.
- R4: With no alarm and no test input, `batt_low` gives code 5, else `chamber_bad` gives code 6, else the code is 0. `trouble_mask` is high exactly when any of `smoke_local`, `remote_in`, `test_pass` or `test_fail` was high.
- R5: A synchronous active-high `rst` clears all outputs (code 0, horn low, mask low, LED select low) at the next edge. Outputs follow the inputs with one clock of latency.
- R6: For codes 1, 2 and 3, `horn_en` follows the cadence. Counting k accepted `tick` pulses since the cadence started, the unit index is (k / PHASE_TICKS) mod 8, and the horn is on for units 0, 2 and 4 and off for units 1, 3, 5, 6 and 7.
- R7: The cadence restarts at unit 0 with zero ticks counted (horn on) in the cycle in which the code becomes 1, 2 or 3 from any different code. A tick in that same cycle is not counted. A change of a lower-priority input that leaves the code unchanged does not restart it.
- R8: For codes 0, 4, 5 and 6, `horn_en` is low and ticks are not counted, so a later horn condition starts from unit 0.
- R9: `led_remote` is high exactly when `alarm_code` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing strobe, one pulse per timebase step |
| smoke_local | input | 1 | Local smoke detected |
| remote_in | input | 1 | Alarm received over the interconnect |
| test_pass | input | 1 | Push-test succeeded |
| test_fail | input | 1 | Push-test failed |
| batt_low | input | 1 | Low battery warning |
| chamber_bad | input | 1 | Degraded chamber warning |
| alarm_code | output | 3 | Winning condition: 0 none, 1 local, 2 remote, 3 test pass, 4 test fail, 5 low battery, 6 chamber |
| horn_en | output | 1 | Horn drive carrying the temporal cadence |
| trouble_mask | output | 1 | Inhibit for the trouble warnings |
| led_remote | output | 1 | LED select, high for a remote alarm |

## Verification
The bench sweeps all 64 combinations of the six condition flags and checks the code, the inhibit and the LED select for each. A design with a priority level out of order would report remote or a test over local smoke, or would let a trouble warning through while a test is active. It then walks two complete cadence cycles tick by tick. A wrong unit length or the wrong gap after the third pulse shows up as the horn being on in an off unit. It also forces a hand-over from local to remote in the middle of an off unit, a tick that lands on the restart cycle, and ticks that arrive while only trouble or a failed test is active. A design that does not restart, or that keeps counting while the horn is idle, would begin the next pattern part-way through.

// File: rtl/alarm_arb_pkg.sv
package alarm_arb_pkg;

  typedef enum logic [2:0] {
    ACODE_NONE    = 3'd0,
    ACODE_LOCAL   = 3'd1,
    ACODE_REMOTE  = 3'd2,
    ACODE_TPASS   = 3'd3,
    ACODE_TFAIL   = 3'd4,
    ACODE_BATT    = 3'd5,
    ACODE_CHAMBER = 3'd6
  } acode_e;

  // Conditions that drive the horn with the temporal cadence.
  function automatic logic code_sounds(acode_e c);
    return (c == ACODE_LOCAL) || (c == ACODE_REMOTE) || (c == ACODE_TPASS);
  endfunction

endpackage

// File: rtl/alarm_prio_sel.sv
module alarm_prio_sel
  import alarm_arb_pkg::*;
(
  input  logic   smoke_local,
  input  logic   remote_in,
  input  logic   test_pass,
  input  logic   test_fail,
  input  logic   batt_low,
  input  logic   chamber_bad,
  output acode_e code,
  output logic   mask
);

  always_comb begin
    if (smoke_local)      code = ACODE_LOCAL;
    else if (remote_in)   code = ACODE_REMOTE;
    else if (test_pass)   code = ACODE_TPASS;
    else if (test_fail)   code = ACODE_TFAIL;
    else if (batt_low)    code = ACODE_BATT;
    else if (chamber_bad) code = ACODE_CHAMBER;
    else                  code = ACODE_NONE;
  end

  // Any alarm or test in progress hides the trouble warnings.
  assign mask = smoke_local | remote_in | test_pass | test_fail;

endmodule

// File: rtl/temporal_cadence.sv
module temporal_cadence #(
  parameter int PHASE_TICKS = 4,
  parameter int PULSES      = 3,
  parameter int GAP_UNITS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic tick,
  output logic on_next
);

  localparam int CYCLE = 2 * PULSES - 1 + GAP_UNITS;
  localparam int CW    = (PHASE_TICKS > 1) ? $clog2(PHASE_TICKS) : 1;
  localparam int UW    = (CYCLE > 1) ? $clog2(CYCLE) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [UW-1:0] unit_q, unit_d;

  always_comb begin
    cnt_d  = cnt_q;
    unit_d = unit_q;
    if (!run || restart) begin
      cnt_d  = '0;
      unit_d = '0;
    end else if (tick) begin
      if (cnt_q == CW'(PHASE_TICKS - 1)) begin
        cnt_d  = '0;
        unit_d = (unit_q == UW'(CYCLE - 1)) ? '0 : unit_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      unit_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      unit_q <= unit_d;
    end
  end

  // On units are the even indices below 2*PULSES-1.
  assign on_next = (unit_d[0] == 1'b0) && (unit_d < UW'(2 * PULSES - 1));

endmodule

// File: rtl/alarm_arbiter.sv
module alarm_arbiter
  import alarm_arb_pkg::*;
#(
  parameter int PHASE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       smoke_local,
  input  logic       remote_in,
  input  logic       test_pass,
  input  logic       test_fail,
  input  logic       batt_low,
  input  logic       chamber_bad,
  output logic [2:0] alarm_code,
  output logic       horn_en,
  output logic       trouble_mask,
  output logic       led_remote
);

  acode_e code_d, code_q;
  logic   mask_d;
  logic   sound_d;
  logic   restart;
  logic   on_next;
  logic   horn_q, mask_q, led_q;

  alarm_prio_sel u_sel (
    .smoke_local (smoke_local),
    .remote_in   (remote_in),
    .test_pass   (test_pass),
    .test_fail   (test_fail),
    .batt_low    (batt_low),
    .chamber_bad (chamber_bad),
    .code        (code_d),
    .mask        (mask_d)
  );

  assign sound_d = code_sounds(code_d);
  assign restart = sound_d && (code_d != code_q);

  temporal_cadence #(
    .PHASE_TICKS (PHASE_TICKS),
    .PULSES      (3),
    .GAP_UNITS   (3)
  ) u_cad (
    .clk     (clk),
    .rst     (rst),
    .run     (sound_d),
    .restart (restart),
    .tick    (tick),
    .on_next (on_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= ACODE_NONE;
      horn_q <= 1'b0;
      mask_q <= 1'b0;
      led_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      horn_q <= sound_d & on_next;
      mask_q <= mask_d;
      led_q  <= (code_d == ACODE_REMOTE);
    end
  end

  assign alarm_code   = code_q;
  assign horn_en      = horn_q;
  assign trouble_mask = mask_q;
  assign led_remote   = led_q;

endmodule

// File: rtl/alarm_arbiter_chk.sv
module alarm_arbiter_chk (
  input logic       clk,
  input logic       rst,
  input logic       smoke_local,
  input logic       remote_in,
  input logic       test_pass,
  input logic       test_fail,
  input logic [2:0] alarm_code,
  input logic       horn_en,
  input logic       trouble_mask,
  input logic       led_remote
);

  logic seen;
  always_ff @(posedge clk) seen <= !rst;

  a_r1_local_wins: assert property (@(posedge clk) disable iff (rst)
    seen && $past(smoke_local) |-> alarm_code == 3'd1);

  a_r2_remote_over_test: assert property (@(posedge clk) disable iff (rst)
    seen && $past(remote_in) && !$past(smoke_local) |-> alarm_code == 3'd2);

  a_r4_mask_follows: assert property (@(posedge clk) disable iff (rst)
    seen |-> trouble_mask == $past(smoke_local | remote_in | test_pass | test_fail));

  a_r8_horn_quiet: assert property (@(posedge clk) disable iff (rst)
    (alarm_code == 3'd0 || alarm_code > 3'd3) |-> !horn_en);

  a_r7_restart_on: assert property (@(posedge clk) disable iff (rst)
    seen && (alarm_code != $past(alarm_code)) && alarm_code >= 3'd1 && alarm_code <= 3'd3
    |-> horn_en);

  a_r9_led_remote: assert property (@(posedge clk) disable iff (rst)
    led_remote == (alarm_code == 3'd2));

endmodule

bind alarm_arbiter alarm_arbiter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .smoke_local  (smoke_local),
  .remote_in    (remote_in),
  .test_pass    (test_pass),
  .test_fail    (test_fail),
  .alarm_code   (alarm_code),
  .horn_en      (horn_en),
  .trouble_mask (trouble_mask),
  .led_remote   (led_remote)
);

// File: tb/test_alarm_arbiter.sv
`timescale 1ns/1ps
module test_alarm_arbiter;

  localparam int P = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic smoke_local = 1'b0, remote_in = 1'b0, test_pass = 1'b0, test_fail = 1'b0;
  logic batt_low = 1'b0, chamber_bad = 1'b0;
  logic [2:0] alarm_code;
  logic horn_en, trouble_mask, led_remote;

  int checks = 0;
  int errors = 0;
  int k = 0;        // ticks counted by the model since the cadence started
  bit done = 1'b0;

  always #10 clk = ~clk;

  alarm_arbiter #(.PHASE_TICKS(P)) i_alarm_arbiter (
    .clk(clk), .rst(rst), .tick(tick),
    .smoke_local(smoke_local), .remote_in(remote_in),
    .test_pass(test_pass), .test_fail(test_fail),
    .batt_low(batt_low), .chamber_bad(chamber_bad),
    .alarm_code(alarm_code), .horn_en(horn_en),
    .trouble_mask(trouble_mask), .led_remote(led_remote)
  );

  function automatic int exp_code(bit l, bit r, bit p, bit f, bit b, bit c);
    if (l) return 1;
    if (r) return 2;
    if (p) return 3;
    if (f) return 4;
    if (b) return 5;
    if (c) return 6;
    return 0;
  endfunction

  function automatic bit exp_horn(int kk);
    int u;
    u = (kk / P) % 8;
    return (u == 0) || (u == 2) || (u == 4);
  endfunction

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Advance one clock; inputs change 2 ns after the edge, outputs read then.
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic set_in(bit l, bit r, bit p, bit f, bit b, bit c);
    smoke_local = l; remote_in = r; test_pass = p;
    test_fail = f; batt_low = b; chamber_bad = c;
  endtask

  // One tick cycle then one idle cycle, horn checked after each.
  task automatic tick_step(string req);
    tick = 1'b1; cyc(); tick = 1'b0;
    k++;
    chk(req, horn_en, exp_horn(k));
    cyc();
    chk(req, horn_en, exp_horn(k));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    // R5: reset state
    chk("R5 code", alarm_code, 0);
    chk("R5 horn", horn_en, 0);
    chk("R5 mask", trouble_mask, 0);
    chk("R5 led", led_remote, 0);
    rst = 1'b0;
    cyc();
    chk("R5 idle code", alarm_code, 0);

    // R1 R2 R3 R4 R9: full sweep of flag combinations, no ticks
    for (int v = 0; v < 64; v++) begin
      int ec;
      bit l, r, p, f, b, c;
      l = v[5]; r = v[4]; p = v[3]; f = v[2]; b = v[1]; c = v[0];
      set_in(l, r, p, f, b, c);
      cyc();
      ec = exp_code(l, r, p, f, b, c);
      chk(l ? "R1 code" : (r ? "R2 code" : ((p | f) ? "R3 code" : "R4 code")),
          alarm_code, ec);
      chk("R4 mask", trouble_mask, int'(l | r | p | f));
      chk("R9 led", led_remote, int'(ec == 2));
      chk("R6 horn level", horn_en, int'(ec >= 1 && ec <= 3));
    end

    // R8: ticks during trouble only are not counted
    set_in(0, 0, 0, 0, 1, 0);
    cyc();
    for (int i = 0; i < 7; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0;
      chk("R8 horn off batt", horn_en, 0);
    end
    set_in(0, 0, 0, 1, 0, 0);
    cyc();
    for (int i = 0; i < 5; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0;
      chk("R8 horn off tfail", horn_en, 0);
      chk("R3 fail code", alarm_code, 4);
    end

    // R6 R7: local alarm starts, two full cadence cycles
    set_in(1, 0, 0, 0, 0, 0);
    cyc();
    k = 0;
    chk("R7 start on", horn_en, 1);
    for (int i = 0; i < 16 * P; i++) tick_step("R6 cadence");
    chk("R1 held code", alarm_code, 1);

    // R7: lower-priority change keeps code, no restart; move into unit 1
    for (int i = 0; i < P; i++) tick_step("R6 into off");
    set_in(1, 1, 0, 0, 0, 0);
    cyc();
    chk("R7 no restart", horn_en, exp_horn(k));
    chk("R7 no restart val", horn_en, 0);

    // R7: hand-over local -> remote restarts, tick on same cycle ignored
    set_in(0, 1, 0, 0, 0, 0);
    tick = 1'b1; cyc(); tick = 1'b0;
    k = 0;
    chk("R7 restart remote", horn_en, 1);
    chk("R9 led remote", led_remote, 1);
    for (int i = 0; i < P - 1; i++) tick_step("R7 after restart");
    tick_step("R7 first off");
    chk("R7 first off val", horn_en, 0);

    // R7: remote -> test pass restarts as well
    set_in(0, 0, 1, 0, 0, 0);
    cyc();
    k = 0;
    chk("R7 restart tpass", horn_en, 1);
    for (int i = 0; i < 8 * P; i++) tick_step("R6 tpass cadence");

    // R8: release to none, horn low
    set_in(0, 0, 0, 0, 0, 0);
    cyc();
    chk("R8 horn none", horn_en, 0);
    chk("R4 none code", alarm_code, 0);

    // R5: reset mid alarm
    set_in(1, 0, 0, 0, 0, 0);
    cyc();
    rst = 1'b1;
    cyc();
    chk("R5 reset code", alarm_code, 0);
    chk("R5 reset horn", horn_en, 0);
    rst = 1'b0;
    cyc();
    chk("R5 after reset", alarm_code, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule